// File: doc/BRIEF.md
# Accumulating 8-bit Calculator Datapath

This block is the arithmetic core of a pocket-calculator style datapath. A single external operand enters on `a_i`. The second operand is an internal accumulator register, so the user enters only one number at a time. A 3-bit operation code picks one of eight functions: four arithmetic and four bitwise. The function's value appears combinationally on `result_o`. On every rising clock edge that value is written back into the accumulator, so each new operation builds on the previous result.

The four arithmetic functions share one two's-complement adder. Subtraction inverts one adder operand and sets the carry-in. A signed-overflow flag covers the arithmetic functions, and an equality flag compares the operand with the accumulator. Both the result and the operand are also split into 4-bit hex digits for a display driver placed outside the block. An active-low asynchronous reset empties the accumulator.

Top module: `calc_accum_alu`

## Requirements
- R1: While `rst_ni` is low the accumulator holds 0x00, and it stays at 0x00 until the first rising clock edge after `rst_ni` goes high.
- R2: Code 000 gives `result_o` = (a + acc) mod 256.
- R3: Code 001 gives (a − acc) mod 256, and code 011 gives (acc − a) mod 256.
- R4: Code 010 gives (a + 1) mod 256, and 0xFF wraps to 0x00.
- R5: The bitwise codes give the following results: 100 gives a AND acc, 101 gives a OR acc, 110 gives a XOR acc, and 111 gives NOT a.
- R6: `overflow_o` is 1 only for codes 000 to 011, and only when the signed 8-bit result of that function differs from the true signed result. Examples are 0x7F+0x01, 0x80−0x01, and 0x7F incremented. For codes 100 to 111, `overflow_o` is 0.
- R7: At every rising clock edge with reset inactive, the accumulator loads the value `result_o` had just before that edge. Later operations then use that value as their second operand.
- R8: `equal_o` is 1 exactly when `a_i` equals the accumulator, whatever the operation code.
- R9: Digit k of `res_hex_o` is bits [4k+3:4k] of `result_o`, and digit k of `a_hex_o` is bits [4k+3:4k] of `a_i`, where k=0 is the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; a rising edge loads the result into the accumulator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | External operand |
| result_o | output | 8 | Combinational function value |
| overflow_o | output | 1 | Signed overflow of the arithmetic functions |
| equal_o | output | 1 | Operand equals accumulator |
| res_hex_o | output | 2x4 | Result split into hex digits |
| a_hex_o | output | 2x4 | Operand split into hex digits |

## Verification
The bench builds the block with its default parameters: an 8-bit word and 4-bit digits, which give two digits per value. An 8-bit word lets random operands reach both signed-overflow boundaries, 0x7F and 0x80, as well as wrap-around at 0xFF, often and without special steering. Directed steps preload the accumulator through code 000 from zero, then hit each overflow corner and the increment wrap. Long random chains check that the accumulated value tracks a bench model across hundreds of edges, with a reset asserted in the middle of a run.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_RSUB = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOTA = 3'b111
  } op_e;
endpackage

// File: rtl/calc_addsub.sv
// Shared two's-complement adder for the four arithmetic codes.
module calc_addsub import calc_pkg::*; #(
  parameter int unsigned WIDTH = 8
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;

  always_comb begin
    unique case (op_i[1:0])
      2'b00:   begin x = a_i; y = b_i;     cin = 1'b0; end
      2'b01:   begin x = a_i; y = ~b_i;    cin = 1'b1; end
      2'b10:   begin x = a_i; y = '0;      cin = 1'b1; end
      default: begin x = b_i; y = ~a_i;    cin = 1'b1; end
    endcase
  end

  assign sum_o = x + y + WIDTH'(cin);
  // signed overflow: same-sign inputs, different-sign result
  assign ovf_o = (x[MSB] == y[MSB]) && (sum_o[MSB] != x[MSB]);
endmodule

// File: rtl/calc_logic.sv
module calc_logic import calc_pkg::*; #(
  parameter int unsigned WIDTH = 8
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (op_i[1:0])
      2'b00:   y_o = a_i & b_i;
      2'b01:   y_o = a_i | b_i;
      2'b10:   y_o = a_i ^ b_i;
      default: y_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/calc_acc_reg.sv
module calc_acc_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/calc_hex_split.sv
module calc_hex_split #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIB   = 4
) (
  input  logic [WIDTH-1:0]                v_i,
  output logic [WIDTH/NIB-1:0][NIB-1:0]   dig_o
);
  localparam int unsigned DIGITS = WIDTH / NIB;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assign dig_o[k] = v_i[k*NIB +: NIB];
  end
endmodule

// File: rtl/calc_accum_alu.sv
module calc_accum_alu import calc_pkg::*; #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIB   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2:0]                    op_i,
  input  logic [WIDTH-1:0]              a_i,
  output logic [WIDTH-1:0]              result_o,
  output logic                          overflow_o,
  output logic                          equal_o,
  output logic [WIDTH/NIB-1:0][NIB-1:0] res_hex_o,
  output logic [WIDTH/NIB-1:0][NIB-1:0] a_hex_o
);
  op_e              op;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] arith_y, logic_y;
  logic             arith_ovf;
  logic             is_logic;

  assign op       = op_e'(op_i);
  assign is_logic = op_i[2];

  calc_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op_i (op), .a_i (a_i), .b_i (acc_q), .sum_o (arith_y), .ovf_o (arith_ovf)
  );

  calc_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op), .a_i (a_i), .b_i (acc_q), .y_o (logic_y)
  );

  assign result_o   = is_logic ? logic_y : arith_y;
  assign overflow_o = !is_logic && arith_ovf;
  assign equal_o    = (a_i == acc_q);

  calc_acc_reg #(.WIDTH(WIDTH)) u_acc (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (result_o), .q_o (acc_q)
  );

  calc_hex_split #(.WIDTH(WIDTH), .NIB(NIB)) u_res_hex (
    .v_i (result_o), .dig_o (res_hex_o)
  );

  calc_hex_split #(.WIDTH(WIDTH), .NIB(NIB)) u_a_hex (
    .v_i (a_i), .dig_o (a_hex_o)
  );
endmodule

// File: rtl/calc_accum_alu_chk.sv
module calc_accum_alu_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NIB   = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2:0]                    op_i,
  input logic [WIDTH-1:0]              a_i,
  input logic [WIDTH-1:0]              result_o,
  input logic                          overflow_o,
  input logic                          equal_o,
  input logic [WIDTH/NIB-1:0][NIB-1:0] res_hex_o,
  input logic [WIDTH-1:0]              acc_i
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> (acc_i == '0));

  a_r7_acc_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (acc_i == $past(result_o)));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[2] |-> !overflow_o);

  a_r8_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equal_o == (a_i == acc_i));

  a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b000) |-> (result_o == WIDTH'(a_i + acc_i)));

  a_r9_low_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hex_o[0] == result_o[NIB-1:0]);
endmodule

bind calc_accum_alu calc_accum_alu_chk #(.WIDTH(WIDTH), .NIB(NIB)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i), .a_i (a_i),
  .result_o (result_o), .overflow_o (overflow_o), .equal_o (equal_o),
  .res_hex_o (res_hex_o), .acc_i (acc_q)
);

// File: tb/sim_calc_accum_alu.sv
`timescale 1ns/1ps
module sim_calc_accum_alu;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      op_i = 3'b000;
  logic [7:0]      a_i = 8'h00;
  logic [7:0]      result_o;
  logic            overflow_o, equal_o;
  logic [1:0][3:0] res_hex_o, a_hex_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_acc = 8'h00;

  always #2 clk_i = ~clk_i;

  calc_accum_alu u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i), .a_i (a_i),
    .result_o (result_o), .overflow_o (overflow_o), .equal_o (equal_o),
    .res_hex_o (res_hex_o), .a_hex_o (a_hex_o)
  );

  function automatic logic [7:0] exp_res(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a + 8'd1;
      3'd3: return b - a;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return a ^ b;
      default: return ~a;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    int sa, sb, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    case (op)
      3'd0: r = sa + sb;
      3'd1: r = sa - sb;
      3'd2: r = sa + 1;
      3'd3: r = sb - sa;
      default: return 1'b0;
    endcase
    return (r > 127) || (r < -128);
  endfunction

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd3: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, check mid-cycle, model load at posedge
  task automatic step(input logic [2:0] op, input logic [7:0] a);
    logic [7:0] e;
    @(negedge clk_i);
    op_i = op;
    a_i  = a;
    #1;
    e = exp_res(op, a, m_acc);
    chk(result_o == e, op_req(op), 32'(result_o), 32'(e));
    chk(overflow_o == exp_ovf(op, a, m_acc), "R6", 32'(overflow_o), 32'(exp_ovf(op, a, m_acc)));
    chk(equal_o == (a == m_acc), "R8", 32'(equal_o), 32'(a == m_acc));
    for (int k = 0; k < 2; k++) begin
      chk(res_hex_o[k] == e[k*4 +: 4], "R9", 32'(res_hex_o[k]), 32'(e[k*4 +: 4]));
      chk(a_hex_o[k] == a[k*4 +: 4], "R9", 32'(a_hex_o[k]), 32'(a[k*4 +: 4]));
    end
    @(posedge clk_i);
    m_acc = e;
  endtask

  // load acc = v from any state: zero it via AND 0, then add v
  task automatic preload(input logic [7:0] v);
    step(3'd4, 8'h00);
    step(3'd0, v);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state seen through code 000 with a = 0
    chk(result_o == 8'h00, "R1", 32'(result_o), 32'h0);
    chk(equal_o == 1'b1, "R1", 32'(equal_o), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7: chaining, acc accumulates 5 + 5 + 5
    step(3'd0, 8'h05);
    step(3'd0, 8'h05);
    step(3'd0, 8'h05);
    @(negedge clk_i); op_i = 3'd0; a_i = 8'h00; #1;
    chk(result_o == 8'h0F, "R7", 32'(result_o), 32'h0F);

    // R6 corners
    preload(8'h01); step(3'd0, 8'h7F);   // 0x7F+0x01 overflow
    preload(8'h01); step(3'd1, 8'h80);   // 0x80-0x01 overflow
    step(3'd2, 8'h7F);                   // inc 0x7F overflow
    step(3'd2, 8'hFF);                   // R4 wrap
    preload(8'h80); step(3'd1, 8'h00);   // 0 - (-128)
    preload(8'h80); step(3'd3, 8'h01);   // -128 - 1
    preload(8'h80); step(3'd0, 8'h80);   // -128 + -128
    preload(8'hA5); step(3'd4, 8'hA5);   // R8 equal, R5 and
    preload(8'h3C); step(3'd6, 8'hFF);
    step(3'd7, 8'h7F);

    // R1: async reset mid-run
    preload(8'h77);
    @(negedge clk_i);
    rst_ni = 1'b0; op_i = 3'd0; a_i = 8'h00; #1;
    chk(result_o == 8'h00, "R1", 32'(result_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_acc = 8'h00;

    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if (($urandom % 8) == 0) a = m_acc;
      step(3'($urandom), a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule